// File: doc/BRIEF.md
# Hardware Thread Context Fork/Yield Controller

This block holds the control state of a small array of hardware thread contexts, each bound to a virtual processing element. A fork request from a running context looks through the contexts in ascending index order. It takes the lowest-numbered one that is free and bound to the caller's processing element. It loads that context's restart PC, forwards one register write into it, and sets its status fields for a freshly started thread. If no context is free, the fork raises a thread exception instead.

A yield request from a context can do one of three things. It can deactivate the caller. It can raise a yield exception when the requested bits are not permitted by the yield mask. It can raise a scheduler-intercept exception for a dirty context. In every case it returns the source value masked by the yield mask.

The contexts' static fields are loaded through a configuration write port: allocatable, halted, active, dirty, delay-slot, run state, mode, address-space ID and binding. Every field is visible on flattened per-context outputs. The result of each request appears one clock after its strobe, together with a single-cycle done pulse.

Top module: `thread_ctx_ctrl`

## Requirements
- R1: An active-low reset clears every context's active and dirty bits, sets the exception code to 0 and holds done, fault and the forwarded write low.
- R2: A fork searches only contexts 0 to `ptc_i`. Values of `ptc_i` above NUM_CTX-1 search all contexts.
- R3: A context qualifies for fork when it is allocatable, not halted, not active and bound to the same processing element as the caller. The lowest qualifying index is chosen.
- R4: On a fork success, the chosen context's restart PC takes `fork_pc_i`. In the cycle after the strobe, `rf_we_o` pulses with `rf_ctx_o` set to the chosen index, `rf_idx_o = fork_rd_i` and `rf_data_o = fork_data_i`.
- R5: On a fork success, the chosen context gets run state 2'b00, delay-slot 0, dirty 1 and active 1. Its mode and address-space ID are copied from the caller.
- R6: When no context qualifies for a fork, `fault_o` pulses, the exception code becomes 3'd1 and no register write is forwarded.
- R7: A yield with source 0 clears the caller's active bit only when the caller is allocatable, not halted and active. Otherwise it changes no state.
- R8: A yield with a positive source that has a bit outside `yield_mask_i` pulses `fault_o` and sets the exception code to 3'd2. A positive source inside the mask does not fault.
- R9: A yield with a negative source other than -2 faults with exception code 3'd4 when `ysi_i` is 1 and the caller's dirty bit is 1. A source of -2, or `ysi_i` = 0, gives no fault.
- R10: Each accepted yield sets `yield_res_o` to the source ANDed with `yield_mask_i`, in the cycle after the strobe.
- R11: `done_o` is high exactly in the cycle after a cycle with a fork or yield strobe. The exception code changes only together with a `fault_o` pulse.
- R12: When fork and yield are strobed together, the fork is performed and the yield is ignored: no state change, and `yield_res_o` is unchanged.
- R13: A configuration write with no fork or yield targeting that context loads all of the context's static fields. The fields are allocatable, halted, active, dirty, delay-slot, run state, mode, address-space ID and binding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ptc_i | input | IDX_W+1 | Highest context index searched by fork |
| ysi_i | input | 1 | Yield scheduler intercept enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Configured context index |
| cfg_da_i | input | 1 | Allocatable bit |
| cfg_halt_i | input | 1 | Halted bit |
| cfg_act_i | input | 1 | Active bit |
| cfg_dirty_i | input | 1 | Dirty bit |
| cfg_tds_i | input | 1 | Delay-slot bit |
| cfg_rnst_i | input | 2 | Run state |
| cfg_ksu_i | input | 2 | Privilege mode |
| cfg_asid_i | input | ASID_W | Address-space ID |
| cfg_pe_i | input | PE_W | Processing element binding |
| caller_i | input | IDX_W | Requesting context index |
| fork_req_i | input | 1 | Fork strobe |
| fork_pc_i | input | PC_W | Restart PC for the new thread |
| fork_rd_i | input | RIDX_W | Destination register index |
| fork_data_i | input | DATA_W | Destination register value |
| yield_req_i | input | 1 | Yield strobe |
| yield_src_i | input | DATA_W | Signed yield source value |
| yield_mask_i | input | DATA_W | Yield permission mask |
| done_o | output | 1 | Request completed |
| fault_o | output | 1 | Thread exception raised |
| excode_o | output | 3 | Last exception code |
| yield_res_o | output | DATA_W | Masked yield result |
| rf_we_o | output | 1 | Forwarded register write strobe |
| rf_ctx_o | output | IDX_W | Context receiving the write |
| rf_idx_o | output | RIDX_W | Register index |
| rf_data_o | output | DATA_W | Register value |
| ctx_da_o | output | NUM_CTX | Allocatable bits |
| ctx_halt_o | output | NUM_CTX | Halted bits |
| ctx_act_o | output | NUM_CTX | Active bits |
| ctx_dirty_o | output | NUM_CTX | Dirty bits |
| ctx_tds_o | output | NUM_CTX | Delay-slot bits |
| ctx_rnst_o | output | 2*NUM_CTX | Run states |
| ctx_ksu_o | output | 2*NUM_CTX | Privilege modes |
| ctx_asid_o | output | ASID_W*NUM_CTX | Address-space IDs |
| ctx_pe_o | output | PE_W*NUM_CTX | Bindings |
| ctx_rpc_o | output | PC_W*NUM_CTX | Restart PCs |

## Verification
The assertions assume that `caller_i` names an existing context. They also assume that a configuration write never targets a context that the same cycle's fork or yield updates, because that update takes priority and would hide the write. The directed stimulus drives all strobes for one cycle each, on the falling edge. It issues configuration writes only in cycles without a fork or yield request, and keeps every caller index below NUM_CTX. The corner stimuli cover the search limit, the halted and foreign-element exclusions, the -2 source value and simultaneous fork and yield.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam logic [2:0] EXC_NONE  = 3'd0;
  localparam logic [2:0] EXC_FORK  = 3'd1;
  localparam logic [2:0] EXC_YMASK = 3'd2;
  localparam logic [2:0] EXC_YSI   = 3'd4;

  localparam logic [1:0] RNST_RUN  = 2'b00;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FORK  = 2'd1,
    OP_YIELD = 2'd2
  } tc_op_e;
endpackage

// File: rtl/tc_ctx_slot.sv
module tc_ctx_slot #(
  parameter int PC_W   = 32,
  parameter int PE_W   = 2,
  parameter int ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_da_i,
  input  logic              cfg_halt_i,
  input  logic              cfg_act_i,
  input  logic              cfg_dirty_i,
  input  logic              cfg_tds_i,
  input  logic [1:0]        cfg_rnst_i,
  input  logic [1:0]        cfg_ksu_i,
  input  logic [ASID_W-1:0] cfg_asid_i,
  input  logic [PE_W-1:0]   cfg_pe_i,
  input  logic              fork_hit_i,
  input  logic [PC_W-1:0]   fork_pc_i,
  input  logic [1:0]        fork_ksu_i,
  input  logic [ASID_W-1:0] fork_asid_i,
  input  logic              yield_clr_i,
  output logic              da_o,
  output logic              halt_o,
  output logic              act_o,
  output logic              dirty_o,
  output logic              tds_o,
  output logic [1:0]        rnst_o,
  output logic [1:0]        ksu_o,
  output logic [ASID_W-1:0] asid_o,
  output logic [PE_W-1:0]   pe_o,
  output logic [PC_W-1:0]   rpc_o
);
  import tc_pkg::*;

  // fork load > yield clear > config write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      da_o    <= 1'b0;
      halt_o  <= 1'b0;
      act_o   <= 1'b0;
      dirty_o <= 1'b0;
      tds_o   <= 1'b0;
      rnst_o  <= 2'b00;
      ksu_o   <= 2'b00;
      asid_o  <= '0;
      pe_o    <= '0;
      rpc_o   <= '0;
    end else if (fork_hit_i) begin
      act_o   <= 1'b1;
      dirty_o <= 1'b1;
      tds_o   <= 1'b0;
      rnst_o  <= RNST_RUN;
      ksu_o   <= fork_ksu_i;
      asid_o  <= fork_asid_i;
      rpc_o   <= fork_pc_i;
    end else if (yield_clr_i) begin
      act_o   <= 1'b0;
    end else if (cfg_we_i) begin
      da_o    <= cfg_da_i;
      halt_o  <= cfg_halt_i;
      act_o   <= cfg_act_i;
      dirty_o <= cfg_dirty_i;
      tds_o   <= cfg_tds_i;
      rnst_o  <= cfg_rnst_i;
      ksu_o   <= cfg_ksu_i;
      asid_o  <= cfg_asid_i;
      pe_o    <= cfg_pe_i;
    end
  end

  // R5
  fork_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fork_hit_i |=> act_o && dirty_o && !tds_o && rnst_o == RNST_RUN
                   && ksu_o == $past(fork_ksu_i) && asid_o == $past(fork_asid_i));

  // R7
  yield_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (yield_clr_i && !fork_hit_i) |=> !act_o);
endmodule

// File: rtl/tc_fork_search.sv
module tc_fork_search #(
  parameter int NUM_CTX = 4,
  parameter int PE_W    = 2,
  localparam int IDX_W  = $clog2(NUM_CTX)
) (
  input  logic [NUM_CTX-1:0]      da_i,
  input  logic [NUM_CTX-1:0]      halt_i,
  input  logic [NUM_CTX-1:0]      act_i,
  input  logic [PE_W*NUM_CTX-1:0] pe_i,
  input  logic [PE_W-1:0]         caller_pe_i,
  input  logic [IDX_W:0]          ptc_i,
  output logic [NUM_CTX-1:0]      hit_o,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [NUM_CTX-1:0] elig;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_elig
    assign elig[g] = da_i[g] && !halt_i[g] && !act_i[g]
                     && (pe_i[g*PE_W +: PE_W] == caller_pe_i)
                     && ((IDX_W+1)'(g) <= ptc_i);
  end

  always_comb begin
    hit_o   = '0;
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (elig[i] && !found_o) begin
        found_o  = 1'b1;
        hit_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tc_yield_eval.sv
module tc_yield_eval #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              ysi_i,
  input  logic              c_da_i,
  input  logic              c_halt_i,
  input  logic              c_act_i,
  input  logic              c_dirty_i,
  output logic              clr_o,
  output logic              fault_o,
  output logic [2:0]        code_o,
  output logic [DATA_W-1:0] res_o
);
  import tc_pkg::*;

  localparam logic [DATA_W-1:0] MINUS_TWO = {{(DATA_W-1){1'b1}}, 1'b0};

  logic is_zero, is_pos, is_neg;

  assign is_zero = (src_i == '0);
  assign is_neg  = src_i[DATA_W-1];
  assign is_pos  = !is_zero && !is_neg;
  assign res_o   = src_i & mask_i;

  always_comb begin
    clr_o   = 1'b0;
    fault_o = 1'b0;
    code_o  = EXC_NONE;
    if (is_zero) begin
      clr_o = c_da_i && !c_halt_i && c_act_i;
    end else if (is_pos) begin
      if ((src_i & ~mask_i) != '0) begin
        fault_o = 1'b1;
        code_o  = EXC_YMASK;
      end
    end else if (src_i != MINUS_TWO) begin
      if (ysi_i && c_dirty_i) begin
        fault_o = 1'b1;
        code_o  = EXC_YSI;
      end
    end
  end
endmodule

// File: rtl/thread_ctx_ctrl.sv
module thread_ctx_ctrl #(
  parameter int NUM_CTX = 4,
  parameter int PC_W    = 32,
  parameter int DATA_W  = 32,
  parameter int RIDX_W  = 5,
  parameter int PE_W    = 2,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(NUM_CTX)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [IDX_W:0]            ptc_i,
  input  logic                      ysi_i,
  input  logic                      cfg_we_i,
  input  logic [IDX_W-1:0]          cfg_idx_i,
  input  logic                      cfg_da_i,
  input  logic                      cfg_halt_i,
  input  logic                      cfg_act_i,
  input  logic                      cfg_dirty_i,
  input  logic                      cfg_tds_i,
  input  logic [1:0]                cfg_rnst_i,
  input  logic [1:0]                cfg_ksu_i,
  input  logic [ASID_W-1:0]         cfg_asid_i,
  input  logic [PE_W-1:0]           cfg_pe_i,
  input  logic [IDX_W-1:0]          caller_i,
  input  logic                      fork_req_i,
  input  logic [PC_W-1:0]           fork_pc_i,
  input  logic [RIDX_W-1:0]         fork_rd_i,
  input  logic [DATA_W-1:0]         fork_data_i,
  input  logic                      yield_req_i,
  input  logic [DATA_W-1:0]         yield_src_i,
  input  logic [DATA_W-1:0]         yield_mask_i,
  output logic                      done_o,
  output logic                      fault_o,
  output logic [2:0]                excode_o,
  output logic [DATA_W-1:0]         yield_res_o,
  output logic                      rf_we_o,
  output logic [IDX_W-1:0]          rf_ctx_o,
  output logic [RIDX_W-1:0]         rf_idx_o,
  output logic [DATA_W-1:0]         rf_data_o,
  output logic [NUM_CTX-1:0]        ctx_da_o,
  output logic [NUM_CTX-1:0]        ctx_halt_o,
  output logic [NUM_CTX-1:0]        ctx_act_o,
  output logic [NUM_CTX-1:0]        ctx_dirty_o,
  output logic [NUM_CTX-1:0]        ctx_tds_o,
  output logic [2*NUM_CTX-1:0]      ctx_rnst_o,
  output logic [2*NUM_CTX-1:0]      ctx_ksu_o,
  output logic [ASID_W*NUM_CTX-1:0] ctx_asid_o,
  output logic [PE_W*NUM_CTX-1:0]   ctx_pe_o,
  output logic [PC_W*NUM_CTX-1:0]   ctx_rpc_o
);
  import tc_pkg::*;

  tc_op_e             op;
  logic [NUM_CTX-1:0] hit, fork_hit, yield_clr;
  logic               found;
  logic [IDX_W-1:0]   hit_idx;
  logic               y_clr, y_fault;
  logic [2:0]         y_code;
  logic [DATA_W-1:0]  y_res;
  logic [PE_W-1:0]    caller_pe;
  logic [1:0]         caller_ksu;
  logic [ASID_W-1:0]  caller_asid;

  always_comb begin
    if (fork_req_i)       op = OP_FORK;
    else if (yield_req_i) op = OP_YIELD;
    else                  op = OP_IDLE;
  end

  assign caller_pe   = ctx_pe_o[caller_i*PE_W +: PE_W];
  assign caller_ksu  = ctx_ksu_o[caller_i*2 +: 2];
  assign caller_asid = ctx_asid_o[caller_i*ASID_W +: ASID_W];

  tc_fork_search #(.NUM_CTX(NUM_CTX), .PE_W(PE_W)) u_search (
    .da_i        (ctx_da_o),
    .halt_i      (ctx_halt_o),
    .act_i       (ctx_act_o),
    .pe_i        (ctx_pe_o),
    .caller_pe_i (caller_pe),
    .ptc_i       (ptc_i),
    .hit_o       (hit),
    .found_o     (found),
    .idx_o       (hit_idx)
  );

  tc_yield_eval #(.DATA_W(DATA_W)) u_yield (
    .src_i     (yield_src_i),
    .mask_i    (yield_mask_i),
    .ysi_i     (ysi_i),
    .c_da_i    (ctx_da_o[caller_i]),
    .c_halt_i  (ctx_halt_o[caller_i]),
    .c_act_i   (ctx_act_o[caller_i]),
    .c_dirty_i (ctx_dirty_o[caller_i]),
    .clr_o     (y_clr),
    .fault_o   (y_fault),
    .code_o    (y_code),
    .res_o     (y_res)
  );

  assign fork_hit = (op == OP_FORK) ? hit : '0;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    assign yield_clr[g] = (op == OP_YIELD) && y_clr && (caller_i == IDX_W'(g));

    tc_ctx_slot #(.PC_W(PC_W), .PE_W(PE_W), .ASID_W(ASID_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
      .cfg_da_i    (cfg_da_i),
      .cfg_halt_i  (cfg_halt_i),
      .cfg_act_i   (cfg_act_i),
      .cfg_dirty_i (cfg_dirty_i),
      .cfg_tds_i   (cfg_tds_i),
      .cfg_rnst_i  (cfg_rnst_i),
      .cfg_ksu_i   (cfg_ksu_i),
      .cfg_asid_i  (cfg_asid_i),
      .cfg_pe_i    (cfg_pe_i),
      .fork_hit_i  (fork_hit[g]),
      .fork_pc_i   (fork_pc_i),
      .fork_ksu_i  (caller_ksu),
      .fork_asid_i (caller_asid),
      .yield_clr_i (yield_clr[g]),
      .da_o        (ctx_da_o[g]),
      .halt_o      (ctx_halt_o[g]),
      .act_o       (ctx_act_o[g]),
      .dirty_o     (ctx_dirty_o[g]),
      .tds_o       (ctx_tds_o[g]),
      .rnst_o      (ctx_rnst_o[g*2 +: 2]),
      .ksu_o       (ctx_ksu_o[g*2 +: 2]),
      .asid_o      (ctx_asid_o[g*ASID_W +: ASID_W]),
      .pe_o        (ctx_pe_o[g*PE_W +: PE_W]),
      .rpc_o       (ctx_rpc_o[g*PC_W +: PC_W])
    );
  end

  // response registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      fault_o     <= 1'b0;
      excode_o    <= EXC_NONE;
      yield_res_o <= '0;
      rf_we_o     <= 1'b0;
      rf_ctx_o    <= '0;
      rf_idx_o    <= '0;
      rf_data_o   <= '0;
    end else begin
      done_o  <= (op != OP_IDLE);
      fault_o <= 1'b0;
      rf_we_o <= 1'b0;
      unique case (op)
        OP_FORK: begin
          if (found) begin
            rf_we_o   <= 1'b1;
            rf_ctx_o  <= hit_idx;
            rf_idx_o  <= fork_rd_i;
            rf_data_o <= fork_data_i;
          end else begin
            fault_o  <= 1'b1;
            excode_o <= EXC_FORK;
          end
        end
        OP_YIELD: begin
          yield_res_o <= y_res;
          if (y_fault) begin
            fault_o  <= 1'b1;
            excode_o <= y_code;
          end
        end
        default: ;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fork_req_i || yield_req_i) |=> done_o);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fork_req_i || yield_req_i) |=> !done_o);
  // R11
  excode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> $stable(excode_o));
  // R6
  fork_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fork_req_i && !found) |=> fault_o && excode_o == EXC_FORK && !rf_we_o);
  // R4
  fork_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> ctx_act_o[rf_ctx_o] && ctx_dirty_o[rf_ctx_o]
                && ctx_rpc_o[rf_ctx_o*PC_W +: PC_W] == $past(fork_pc_i));
  // R12
  fork_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fork_req_i && yield_req_i) |=> $stable(yield_res_o));
  // R3
  fork_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fork_req_i |-> $onehot0(fork_hit));
endmodule

// File: tb/thread_ctx_ctrl_tb_top.sv
module thread_ctx_ctrl_tb_top;
  localparam int N = 4;
  localparam int IW = 2;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [IW:0] ptc = 3'd3;
  logic ysi = 1'b0;
  logic cfg_we = 0, cfg_da = 0, cfg_halt = 0, cfg_act = 0, cfg_dirty = 0, cfg_tds = 0;
  logic [IW-1:0] cfg_idx = '0, caller = '0;
  logic [1:0] cfg_rnst = '0, cfg_ksu = '0;
  logic [7:0] cfg_asid = '0;
  logic [1:0] cfg_pe = '0;
  logic fork_req = 0, yield_req = 0;
  logic [31:0] fork_pc = '0, fork_data = '0, ysrc = '0, ymask = '0;
  logic [4:0] fork_rd = '0;

  logic done, fault, rf_we;
  logic [2:0] excode;
  logic [DW-1:0] yres, rf_data;
  logic [IW-1:0] rf_ctx;
  logic [4:0] rf_idx;
  logic [N-1:0] c_da, c_halt, c_act, c_dirty, c_tds;
  logic [2*N-1:0] c_rnst, c_ksu;
  logic [8*N-1:0] c_asid;
  logic [2*N-1:0] c_pe;
  logic [32*N-1:0] c_rpc;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  thread_ctx_ctrl #(.NUM_CTX(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ptc_i(ptc), .ysi_i(ysi),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_da_i(cfg_da), .cfg_halt_i(cfg_halt),
    .cfg_act_i(cfg_act), .cfg_dirty_i(cfg_dirty), .cfg_tds_i(cfg_tds),
    .cfg_rnst_i(cfg_rnst), .cfg_ksu_i(cfg_ksu), .cfg_asid_i(cfg_asid), .cfg_pe_i(cfg_pe),
    .caller_i(caller), .fork_req_i(fork_req), .fork_pc_i(fork_pc), .fork_rd_i(fork_rd),
    .fork_data_i(fork_data), .yield_req_i(yield_req), .yield_src_i(ysrc),
    .yield_mask_i(ymask), .done_o(done), .fault_o(fault), .excode_o(excode),
    .yield_res_o(yres), .rf_we_o(rf_we), .rf_ctx_o(rf_ctx), .rf_idx_o(rf_idx),
    .rf_data_o(rf_data), .ctx_da_o(c_da), .ctx_halt_o(c_halt), .ctx_act_o(c_act),
    .ctx_dirty_o(c_dirty), .ctx_tds_o(c_tds), .ctx_rnst_o(c_rnst), .ctx_ksu_o(c_ksu),
    .ctx_asid_o(c_asid), .ctx_pe_o(c_pe), .ctx_rpc_o(c_rpc)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input bit da, input bit halt, input bit act,
                     input bit dirty, input bit tds, input logic [1:0] rnst,
                     input logic [1:0] ksu, input logic [7:0] asid, input logic [1:0] pe);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_da = da; cfg_halt = halt; cfg_act = act;
    cfg_dirty = dirty; cfg_tds = tds; cfg_rnst = rnst; cfg_ksu = ksu;
    cfg_asid = asid; cfg_pe = pe;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // drives a one-cycle strobe; returns at the next falling edge with results valid
  task automatic do_req(input bit f, input bit y, input int who,
                        input logic [31:0] pc, input logic [4:0] rd, input logic [31:0] data,
                        input logic [31:0] src, input logic [31:0] mask);
    @(negedge clk);
    caller = IW'(who); fork_req = f; yield_req = y;
    fork_pc = pc; fork_rd = rd; fork_data = data; ysrc = src; ymask = mask;
    @(negedge clk);
    fork_req = 0; yield_req = 0;
  endtask

  task automatic t_reset;
    chk("R1 active", 64'(c_act), 0);
    chk("R1 dirty", 64'(c_dirty), 0);
    chk("R1 excode", 64'(excode), 0);
    chk("R1 done", 64'({done, fault, rf_we}), 0);
  endtask

  task automatic t_setup;
    cfg(0, 0, 0, 1, 0, 0, 2'b00, 2'b10, 8'h5A, 2'd0);
    cfg(1, 1, 1, 0, 0, 0, 2'b01, 2'b00, 8'h00, 2'd0);
    cfg(2, 1, 0, 0, 0, 0, 2'b01, 2'b00, 8'h00, 2'd1);
    cfg(3, 1, 0, 0, 0, 1, 2'b11, 2'b01, 8'h11, 2'd0);
    chk("R13 cfg fields ctx3", 64'({c_da[3], c_halt[3], c_act[3], c_tds[3], c_rnst[7:6], c_ksu[7:6], c_asid[31:24], c_pe[7:6]}),
        64'({1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'b01, 8'h11, 2'd0}));
  endtask

  task automatic t_fork_ok;
    do_req(1, 0, 0, 32'h0000_4000, 5'd7, 32'hCAFE_0001, '0, '0);
    chk("R11 done after fork", 64'(done), 1);
    chk("R3 skips halted and foreign ctx", 64'({rf_we, rf_ctx}), 64'({1'b1, 2'd3}));
    chk("R4 forwarded write", 64'({rf_idx, rf_data}), 64'({5'd7, 32'hCAFE_0001}));
    chk("R4 restart pc", 64'(c_rpc[3*32 +: 32]), 64'h4000);
    chk("R5 status fields", 64'({c_act[3], c_dirty[3], c_tds[3], c_rnst[7:6], c_ksu[7:6], c_asid[31:24]}),
        64'({1'b1, 1'b1, 1'b0, 2'b00, 2'b10, 8'h5A}));
    chk("R6 no fault on success", 64'(fault), 0);
    @(negedge clk);
    chk("R11 done single cycle", 64'({done, rf_we}), 0);
  endtask

  task automatic t_fork_none;
    do_req(1, 0, 0, 32'h1234, 5'd1, 32'h1, '0, '0);
    chk("R6 fault when none free", 64'({fault, excode, rf_we}), 64'({1'b1, 3'd1, 1'b0}));
  endtask

  task automatic t_limit;
    cfg(1, 1, 0, 0, 0, 0, 2'b01, 2'b00, 8'h00, 2'd0);
    cfg(3, 1, 0, 0, 0, 1, 2'b11, 2'b01, 8'h11, 2'd0);
    ptc = 3'd0;
    do_req(1, 0, 0, 32'h2000, 5'd2, 32'h22, '0, '0);
    chk("R2 limit 0 excludes ctx1", 64'({fault, rf_we, c_act[1]}), 64'({1'b1, 1'b0, 1'b0}));
    ptc = 3'd3;
    do_req(1, 0, 0, 32'h3000, 5'd3, 32'h33, '0, '0);
    chk("R3 lowest index wins", 64'({rf_we, rf_ctx, c_act[1], c_act[3]}), 64'({1'b1, 2'd1, 1'b1, 1'b0}));
  endtask

  task automatic t_yield_zero;
    cfg(3, 1, 0, 1, 0, 0, 2'b00, 2'b01, 8'h11, 2'd0);
    do_req(0, 1, 3, '0, '0, '0, 32'd0, 32'hF);
    chk("R7 yield 0 deactivates", 64'({c_act[3], fault}), 0);
    chk("R10 result zero", 64'(yres), 0);
    do_req(0, 1, 0, '0, '0, '0, 32'd0, 32'hF);
    chk("R7 non-allocatable caller stays active", 64'(c_act[0]), 1);
  endtask

  task automatic t_yield_pos;
    do_req(0, 1, 1, '0, '0, '0, 32'h6, 32'h2);
    chk("R8 masked bits fault", 64'({fault, excode}), 64'({1'b1, 3'd2}));
    chk("R10 result masked", 64'(yres), 64'h2);
    do_req(0, 1, 1, '0, '0, '0, 32'h2, 32'h3);
    chk("R8 allowed bits no fault", 64'({fault, excode}), 64'({1'b0, 3'd2}));
    chk("R10 result", 64'(yres), 64'h2);
  endtask

  task automatic t_yield_neg;
    ysi = 1;
    do_req(0, 1, 1, '0, '0, '0, 32'hFFFF_FFFF, 32'hFF);
    chk("R9 intercept fault", 64'({fault, excode}), 64'({1'b1, 3'd4}));
    chk("R10 negative result", 64'(yres), 64'hFF);
    do_req(0, 1, 1, '0, '0, '0, 32'hFFFF_FFFE, 32'hFF);
    chk("R9 minus two no fault", 64'({done, fault, excode}), 64'({1'b1, 1'b0, 3'd4}));
    ysi = 0;
    do_req(0, 1, 1, '0, '0, '0, 32'hFFFF_FFFF, 32'hFF);
    chk("R9 intercept off no fault", 64'(fault), 0);
  endtask

  task automatic t_both;
    ptc = 3'd7;
    do_req(1, 1, 1, 32'h5000, 5'd9, 32'h99, 32'd0, 32'h0);
    chk("R12 fork performed", 64'({rf_we, rf_ctx, c_act[3]}), 64'({1'b1, 2'd3, 1'b1}));
    chk("R12 yield ignored", 64'({c_act[1], yres}), 64'({1'b1, 32'hFF}));
    chk("R2 clamp searched ctx3", 64'(c_rpc[3*32 +: 32]), 64'h5000);
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk("R1 reset clears act dirty excode", 64'({c_act, c_dirty, excode}), 0);
    rst_ni = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    t_setup();
    t_fork_ok();
    t_fork_none();
    t_limit();
    t_yield_zero();
    t_yield_pos();
    t_yield_neg();
    t_both();
    t_mid_reset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule